// File: doc/BRIEF.md
# Atomic Read-Modify-Write Register Unit

This block holds one shared data word that several requesters reach through one request port each. Each request names an operation and up to two operands. A round-robin arbiter accepts exactly one request per clock cycle. The accepted operation reads, computes and writes back in that same cycle, so no other requester can act between its read and its write.

Every accepted request gets one response in the following cycle, on the issuing requester's response lanes only. The response carries a data word, normally the register value before the operation, and a success flag. Load-link and store-conditional are built on one reservation bit per requester. Any real modification of the register clears every reservation. Store-conditional therefore fails after an intervening change, even when the value has since been written back to what the load-link saw.

Operation codes on `req_op_i`: 0 read, 1 write, 2 test-and-set, 3 fetch-and-add, 4 compare-and-swap, 5 load-link, 6 store-conditional.

Top module: `atomic_reg_unit`

## Requirements
- R1: After reset the register reads 0, no response is valid, and no requester holds a reservation, so a store-conditional (code 6) fails.
- R2: A write (code 1) stores operand A, returns the previous value and flags success. A read (code 0) returns the current value and leaves the register unchanged.
- R3: A test-and-set (code 2) returns the previous value and leaves the register at 1.
- R4: A fetch-and-add (code 3) returns the previous value and stores the previous value plus operand A, modulo 2^DATA_W.
- R5: A compare-and-swap (code 4) stores operand B and flags success only when the register equals operand A. Otherwise it leaves the register unchanged and flags failure. Either way it returns the previous value.
- R6: A load-link (code 5) returns the current value and arms the issuer's reservation. A following store-conditional (code 6) from the same requester stores operand A and flags success if no modification came in between.
- R7: A store-conditional fails and does not write if any modification happened after the issuer's load-link, including a sequence of writes that restored the loaded value.
- R8: A store-conditional with no armed reservation flags failure and leaves the register unchanged.
- R9: A write, test-and-set, fetch-and-add, successful compare-and-swap or successful store-conditional clears all reservations. A read, a load-link or a failed compare-and-swap leaves other requesters' reservations intact.
- R10: At most one request is accepted per cycle, `req_ready_o` marks the accepted one, and its response appears one cycle later on the issuer's lanes alone. Simultaneous fetch-and-adds are applied one after another without loss.
- R11: Grants rotate round-robin, so a requester holding a valid request is accepted within N_REQ cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_REQ | Request valid per requester |
| req_ready_o | output | N_REQ | Request accepted this cycle (one-hot or zero) |
| req_op_i | input | N_REQ x 3 | Operation code per requester |
| req_a_i | input | N_REQ x DATA_W | Operand A: store value, addend or compare value |
| req_b_i | input | N_REQ x DATA_W | Operand B: swap value for compare-and-swap |
| rsp_valid_o | output | N_REQ | Response valid per requester |
| rsp_data_o | output | N_REQ x DATA_W | Response data, normally the previous value |
| rsp_ok_o | output | N_REQ | Success flag |

## Verification
Two things can happen in the same cycle: contention in the arbiter and the atomic update of the register. The first case is provoked by raising four fetch-and-adds together. The bench then checks that the grants come one per cycle and that each returned old value equals the start value plus the addends of the requesters served earlier, which shows that no update was lost. The second case is a store-conditional and a write from another requester raised in the same cycle. The bench watches `req_ready_o` to see which is accepted first. It expects the conditional store to succeed only if it won, and it expects the final value to be the write's operand either way.

// File: rtl/arw_pkg.sv
package arw_pkg;
  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_RD  = 3'd0,
    OP_WR  = 3'd1,
    OP_TAS = 3'd2,
    OP_FAA = 3'd3,
    OP_CAS = 3'd4,
    OP_LL  = 3'd5,
    OP_SC  = 3'd6
  } op_e;
endpackage

// File: rtl/arw_rr_arb.sv
module arw_rr_arb #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o,
  output logic             gnt_any_o
);
  localparam int unsigned CNT_W = $clog2(N + 1);

  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    gnt_any_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr_q) + k) % N;
      if (!gnt_any_o && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        gnt_idx_o  = IDX_W'(idx);
        gnt_any_o  = 1'b1;
      end
    end
  end

  // pointer moves past the winner
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (gnt_any_o) ptr_q <= (gnt_idx_o == IDX_W'(N - 1)) ? '0 : gnt_idx_o + 1'b1;
  end

  p_one_grant_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_grant_has_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  for (genvar g = 0; g < N; g++) begin : g_wait
    logic [CNT_W-1:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  wait_q <= '0;
      else if (req_i[g] && !gnt_o[g]) wait_q <= wait_q + 1'b1;
      else                          wait_q <= '0;
    end
    p_rr_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wait_q < CNT_W'(N));
  end
endmodule

// File: rtl/arw_op_exec.sv
module arw_op_exec
  import arw_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  op_e          op_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         link_i,
  output logic         wr_o,
  output logic [W-1:0] nxt_o,
  output logic [W-1:0] rdata_o,
  output logic         ok_o,
  output logic         clr_o,
  output logic         arm_o
);
  always_comb begin
    wr_o    = 1'b0;
    nxt_o   = cur_i;
    rdata_o = cur_i;
    ok_o    = 1'b1;
    clr_o   = 1'b0;
    arm_o   = 1'b0;
    unique case (op_i)
      OP_RD: ;
      OP_WR: begin
        wr_o = 1'b1; nxt_o = opa_i; clr_o = 1'b1;
      end
      OP_TAS: begin
        wr_o = 1'b1; nxt_o = W'(1); clr_o = 1'b1;
      end
      OP_FAA: begin
        wr_o = 1'b1; nxt_o = cur_i + opa_i; clr_o = 1'b1;
      end
      OP_CAS: begin
        ok_o = (cur_i == opa_i);
        wr_o = ok_o; nxt_o = opb_i; clr_o = ok_o;
      end
      OP_LL: arm_o = 1'b1;
      OP_SC: begin
        ok_o = link_i;
        wr_o = link_i; nxt_o = opa_i; clr_o = link_i;
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/arw_link_track.sv
module arw_link_track #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             arm_i,
  input  logic             clr_i,
  output logic [N-1:0]     armed_o
);
  for (genvar g = 0; g < N; g++) begin : g_link
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              armed_o[g] <= 1'b0;
      else if (fire_i && clr_i)                 armed_o[g] <= 1'b0;
      else if (fire_i && arm_i && idx_i == IDX_W'(g)) armed_o[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/atomic_reg_unit.sv
module atomic_reg_unit
  import arw_pkg::*;
#(
  parameter int unsigned N_REQ  = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REQ-1:0]              req_valid_i,
  output logic [N_REQ-1:0]              req_ready_o,
  input  logic [N_REQ-1:0][OP_W-1:0]    req_op_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_a_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_b_i,
  output logic [N_REQ-1:0]              rsp_valid_o,
  output logic [N_REQ-1:0][DATA_W-1:0]  rsp_data_o,
  output logic [N_REQ-1:0]              rsp_ok_o
);
  localparam int unsigned IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [N_REQ-1:0]  gnt;
  logic [IDX_W-1:0]  gnt_idx;
  logic              fire;
  logic [N_REQ-1:0]  armed;
  logic [DATA_W-1:0] data_q;

  op_e               sel_op;
  logic [DATA_W-1:0] sel_a, sel_b, nxt, rdata;
  logic              sel_link, wr, ok, clr, arm;

  arw_rr_arb #(.N(N_REQ), .IDX_W(IDX_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_valid_i),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx),
    .gnt_any_o (fire)
  );

  assign req_ready_o = gnt;
  assign sel_op      = op_e'(req_op_i[gnt_idx]);
  assign sel_a       = req_a_i[gnt_idx];
  assign sel_b       = req_b_i[gnt_idx];
  assign sel_link    = armed[gnt_idx];

  arw_op_exec #(.W(DATA_W)) u_exec (
    .op_i    (sel_op),
    .cur_i   (data_q),
    .opa_i   (sel_a),
    .opb_i   (sel_b),
    .link_i  (sel_link),
    .wr_o    (wr),
    .nxt_o   (nxt),
    .rdata_o (rdata),
    .ok_o    (ok),
    .clr_o   (clr),
    .arm_o   (arm)
  );

  arw_link_track #(.N(N_REQ), .IDX_W(IDX_W)) u_link (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .idx_i   (gnt_idx),
    .arm_i   (arm),
    .clr_i   (clr),
    .armed_o (armed)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        data_q <= '0;
    else if (fire && wr) data_q <= nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= '0;
      rsp_data_o  <= '0;
      rsp_ok_o    <= '0;
    end else begin
      rsp_valid_o <= fire ? gnt : '0;
      if (fire) begin
        rsp_data_o[gnt_idx] <= rdata;
        rsp_ok_o[gnt_idx]   <= ok;
      end
    end
  end

  p_tas_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sel_op == OP_TAS) |=> data_q == DATA_W'(1));
  p_faa_sum_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sel_op == OP_FAA) |=> data_q == DATA_W'($past(data_q) + $past(sel_a)));
  p_sc_nolink_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sel_op == OP_SC && !sel_link) |=> $stable(data_q));
  p_wr_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sel_op == OP_WR) |=> armed == '0);
  p_rd_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && sel_op == OP_RD) |=> $stable(armed) && $stable(data_q));
  p_rsp_issuer_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o == $past(gnt));
endmodule

// File: tb/atomic_reg_unit_bench.sv
module atomic_reg_unit_bench;
  localparam int N = 4;
  localparam int W = 16;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [N-1:0]          valid = '0;
  logic [N-1:0]          ready;
  logic [N-1:0][2:0]     op = '0;
  logic [N-1:0][W-1:0]   a = '0;
  logic [N-1:0][W-1:0]   b = '0;
  logic [N-1:0]          rsp_valid;
  logic [N-1:0][W-1:0]   rsp_data;
  logic [N-1:0]          rsp_ok;

  int total = 0;
  int bad   = 0;
  logic [N-1:0] last_rv;

  always #2.5 clk = ~clk;

  atomic_reg_unit #(.N_REQ(N), .DATA_W(W)) u_atomic_reg_unit (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (valid),
    .req_ready_o (ready),
    .req_op_i    (op),
    .req_a_i     (a),
    .req_b_i     (b),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data),
    .rsp_ok_o    (rsp_ok)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // single requester, accepted at once; response sampled one cycle later
  task automatic do_op(input int r, input logic [2:0] o, input logic [W-1:0] x,
                       input logic [W-1:0] y, output logic [W-1:0] d, output logic k);
    @(negedge clk);
    op[r] = o; a[r] = x; b[r] = y; valid[r] = 1'b1;
    @(negedge clk);
    valid[r] = 1'b0;
    d = rsp_data[r]; k = rsp_ok[r]; last_rv = rsp_valid;
  endtask

  task automatic t_reset;
    logic [W-1:0] d; logic k;
    @(negedge clk);
    chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst_n = 1'b1;
    do_op(2, 3'd6, 16'h0042, 0, d, k);
    chk("R1 sc after reset fails", 32'(k), 0);
    do_op(1, 3'd0, 0, 0, d, k);
    chk("R1 value after reset", 32'(d), 0);
  endtask

  task automatic t_rw;
    logic [W-1:0] d; logic k;
    do_op(0, 3'd1, 16'h1234, 0, d, k);
    chk("R2 write returns old", 32'(d), 0);
    chk("R2 write ok", 32'(k), 1);
    do_op(1, 3'd0, 0, 0, d, k);
    chk("R2 read value", 32'(d), 32'h1234);
    chk("R10 rsp only on issuer", 32'(last_rv), 32'b0010);
    do_op(3, 3'd0, 0, 0, d, k);
    chk("R2 read no change", 32'(d), 32'h1234);
  endtask

  task automatic t_tas;
    logic [W-1:0] d; logic k;
    do_op(0, 3'd1, 0, 0, d, k);
    do_op(1, 3'd2, 0, 0, d, k);
    chk("R3 tas old 0", 32'(d), 0);
    do_op(2, 3'd2, 0, 0, d, k);
    chk("R3 tas old 1", 32'(d), 1);
    do_op(0, 3'd0, 0, 0, d, k);
    chk("R3 value 1", 32'(d), 1);
  endtask

  task automatic t_faa;
    logic [W-1:0] d; logic k;
    do_op(0, 3'd1, 16'hFFFE, 0, d, k);
    do_op(3, 3'd3, 16'h0005, 0, d, k);
    chk("R4 faa old", 32'(d), 32'hFFFE);
    do_op(0, 3'd0, 0, 0, d, k);
    chk("R4 faa wraps", 32'(d), 3);
  endtask

  task automatic t_cas;
    logic [W-1:0] d; logic k;
    do_op(0, 3'd1, 16'h0007, 0, d, k);
    do_op(1, 3'd4, 16'h0008, 16'h0009, d, k);
    chk("R5 cas mismatch flag", 32'(k), 0);
    chk("R5 cas mismatch old", 32'(d), 7);
    do_op(0, 3'd0, 0, 0, d, k);
    chk("R5 cas mismatch no write", 32'(d), 7);
    do_op(2, 3'd4, 16'h0007, 16'h0009, d, k);
    chk("R5 cas match flag", 32'(k), 1);
    do_op(0, 3'd0, 0, 0, d, k);
    chk("R5 cas match value", 32'(d), 9);
  endtask

  task automatic t_llsc;
    logic [W-1:0] d; logic k;
    do_op(0, 3'd5, 0, 0, d, k);
    chk("R6 ll value", 32'(d), 9);
    do_op(0, 3'd6, 16'h0055, 0, d, k);
    chk("R6 sc ok", 32'(k), 1);
    do_op(1, 3'd0, 0, 0, d, k);
    chk("R6 sc stored", 32'(d), 32'h55);
    do_op(0, 3'd6, 16'h0066, 0, d, k);
    chk("R8 sc reused link fails", 32'(k), 0);
    do_op(1, 3'd0, 0, 0, d, k);
    chk("R8 failed sc no write", 32'(d), 32'h55);
  endtask

  task automatic t_aba;
    logic [W-1:0] d, v; logic k;
    do_op(0, 3'd5, 0, 0, v, k);
    do_op(1, 3'd1, 16'h00AA, 0, d, k);
    do_op(1, 3'd1, v, 0, d, k);
    do_op(0, 3'd6, 16'h0077, 0, d, k);
    chk("R7 sc after restore fails", 32'(k), 0);
    do_op(2, 3'd0, 0, 0, d, k);
    chk("R7 value kept", 32'(d), 32'(v));
  endtask

  task automatic t_keep;
    logic [W-1:0] d; logic k;
    do_op(0, 3'd5, 0, 0, d, k);
    do_op(1, 3'd0, 0, 0, d, k);
    do_op(1, 3'd5, 0, 0, d, k);
    do_op(2, 3'd4, 16'hBEEF, 16'h0001, d, k);
    do_op(0, 3'd6, 16'h0123, 0, d, k);
    chk("R9 link survives rd/ll/failed cas", 32'(k), 1);
    do_op(1, 3'd6, 16'h0456, 0, d, k);
    chk("R9 sc success clears others", 32'(k), 0);
    do_op(3, 3'd0, 0, 0, d, k);
    chk("R9 value", 32'(d), 32'h0123);
  endtask

  task automatic t_race_faa;
    logic [W-1:0] d; logic k;
    logic [W-1:0] olds [N];
    int when [N];
    logic [N-1:0] done;
    int acc;
    do_op(0, 3'd1, 16'd100, 0, d, k);
    done = '0;
    @(negedge clk);
    for (int r = 0; r < N; r++) begin
      op[r] = 3'd3; a[r] = W'(r + 1); valid[r] = 1'b1; when[r] = 99; olds[r] = '0;
    end
    for (int c = 1; c <= 2 * N; c++) begin
      #1;
      chk("R10 single ready", 32'($countones(ready)), 32'($countones(ready) > 1 ? 1 : $countones(ready)));
      @(negedge clk);
      chk("R10 single response", 32'($countones(rsp_valid) <= 1), 1);
      for (int r = 0; r < N; r++) begin
        if (rsp_valid[r]) begin
          olds[r] = rsp_data[r]; when[r] = c; done[r] = 1'b1; valid[r] = 1'b0;
        end
      end
      if (done == '1) break;
    end
    acc = 100;
    for (int c = 1; c <= N; c++) begin
      for (int r = 0; r < N; r++) begin
        if (when[r] == c) begin
          chk("R10 faa race old value", 32'(olds[r]), 32'(acc));
          acc += r + 1;
        end
      end
    end
    for (int r = 0; r < N; r++) chk("R11 served within N", 32'(when[r] <= N), 1);
    do_op(0, 3'd0, 0, 0, d, k);
    chk("R10 faa race total", 32'(d), 110);
  endtask

  task automatic t_race_sc;
    logic [W-1:0] d; logic k;
    logic sc_first, sc_ok;
    logic [1:0] got;
    do_op(0, 3'd1, 16'h0010, 0, d, k);
    do_op(2, 3'd5, 0, 0, d, k);
    @(negedge clk);
    op[2] = 3'd6; a[2] = 16'h0020; valid[2] = 1'b1;
    op[3] = 3'd1; a[3] = 16'h0030; valid[3] = 1'b1;
    #1;
    sc_first = ready[2];
    got = '0; sc_ok = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (rsp_valid[2]) begin got[0] = 1'b1; sc_ok = rsp_ok[2]; valid[2] = 1'b0; end
      if (rsp_valid[3]) begin got[1] = 1'b1; valid[3] = 1'b0; end
      if (got == 2'b11) break;
    end
    chk("R10 both served", 32'(got), 3);
    chk("R7 sc vs write ordering", 32'(sc_ok), 32'(sc_first));
    do_op(0, 3'd0, 0, 0, d, k);
    chk("R10 sc race final", 32'(d), 32'h30);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_rw();
    t_tas();
    t_faa();
    t_cas();
    t_llsc();
    t_aba();
    t_keep();
    t_race_faa();
    t_race_sc();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule